// File: doc/BRIEF.md
# Packed Endpoint Buffer Allocator

This block divides one shared packet buffer RAM among a fixed set of device endpoints. Each endpoint has a configuration word with an enable bit, an allocate bit, a 3-bit size code and a bank bit. Allocated endpoints get regions placed back to back in ascending endpoint number. Endpoints that are not allocated take no space. When one endpoint is allocated or released, every higher endpoint's region moves. Lower endpoints keep their place.

For each endpoint the block publishes the base address, the region length, a valid flag and an overflow flag. It also keeps a sticky relocated flag, which tells the controller that data held in a moved region can no longer be trusted. A second path turns an endpoint-relative byte access into a physical RAM request and checks it against the region bounds. That path is a valid/ready stream. A legal request passes straight through to the RAM port, and the RAM side's ready is the back-pressure. An illegal request is consumed in its own cycle and is flagged with an error.

Top module: `ep_buf_alloc`

## Requirements
- R1: After reset, every base, length, valid, overflow, relocated and enable output reads zero.
- R2: A configuration write is reflected on the layout outputs from the clock edge that accepts it. The length of an allocated endpoint is 8 << code bytes for codes 0 to 6, and 512 bytes for code 7. The bank bit doubles that length. An endpoint that is not allocated has length 0.
- R3: An allocated endpoint whose region ends past RAM_BYTES has its overflow flag set. That endpoint and every endpoint above it have valid cleared. Endpoints below it stay valid.
- R4: Releasing endpoint k moves every higher endpoint down by the length of k's region. Lower endpoints keep their base.
- R5: Allocating endpoint k moves every higher endpoint up by the length of k's new region. Lower endpoints keep their base.
- R6: Clearing an endpoint's enable bit while it stays allocated changes no base, length or valid output.
- R7: The relocated flag of an endpoint is set when its base changes while it is allocated both before and after the write. The flag holds until a 1 is written to the matching bit of rel_clr. A new set in the same cycle wins over the clear.
- R8: A legal access drives ram_addr = base + offset and ram_req_valid, and drives ram_we only for writes.
- R9: An access is an error when its endpoint is not valid or its offset is not below the region length. An error asserts acc_err and acc_ready, and drives neither ram_req_valid nor ram_we.
- R10: A legal access is accepted only when ram_req_ready is high. acc_ready follows ram_req_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write the configuration word of endpoint cfg_ep |
| cfg_ep | input | EP_W (3) | Endpoint being configured |
| cfg_en | input | 1 | Enable bit |
| cfg_alloc | input | 1 | Allocate bit |
| cfg_size | input | 3 | Size code |
| cfg_bank | input | 1 | Bank bit, doubles the region |
| rel_clr | input | NUM_EP | Write-one-to-clear for the relocated flags |
| ep_enabled | output | NUM_EP | Stored enable bits |
| ep_base | output | NUM_EP*SUM_W (112) | Base address per endpoint, endpoint k at bits k*SUM_W |
| ep_bytes | output | NUM_EP*SUM_W (112) | Region length per endpoint, same packing |
| ep_valid | output | NUM_EP | Region allocated and within the RAM |
| ep_ovf | output | NUM_EP | Region ends past the RAM |
| ep_reloc | output | NUM_EP | Sticky relocated flags |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request consumed |
| acc_ep | input | EP_W (3) | Endpoint addressed |
| acc_off | input | OFF_W (10) | Byte offset inside the region |
| acc_write | input | 1 | Access is a write |
| ram_req_valid | output | 1 | Physical RAM request valid |
| ram_req_ready | input | 1 | RAM can take a request |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W (8) | Physical RAM byte address |
| acc_err | output | 1 | Current access is out of bounds or hits an invalid endpoint |

## Verification
The assertions assume the access inputs stay stable while a legal request waits on ram_req_ready. They also assume that allocations are built up in ascending endpoint order, and that a released endpoint is only allocated again in place. The bench holds each access at fixed values for the whole time it is checked. Its configuration sequences only allocate upward, or release one endpoint and then allocate that same endpoint again. Every cfg_ep and acc_ep value it drives names an existing endpoint.

// File: rtl/ep_alloc_pkg.sv
package ep_alloc_pkg;
  typedef struct packed {
    logic       en;
    logic       alloc;
    logic [2:0] code;
    logic       bank;
  } ep_cfg_t;

  // Region length in bytes: 8 << code, code 7 clamps to 512, bank doubles.
  function automatic logic [10:0] region_bytes(input logic [2:0] code, input logic bank);
    logic [10:0] b;
    b = (code == 3'd7) ? 11'd512 : (11'd8 << code);
    if (bank) b = b << 1;
    return b;
  endfunction
endpackage

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs
  import ep_alloc_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int EP_W   = $clog2(NUM_EP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [EP_W-1:0] cfg_ep,
  input  ep_cfg_t         cfg_word,
  output ep_cfg_t         cfg_q [NUM_EP],
  output ep_cfg_t         cfg_d [NUM_EP]
);
  for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
    always_comb begin
      cfg_d[k] = cfg_q[k];
      if (cfg_we && (cfg_ep == EP_W'(k))) cfg_d[k] = cfg_word;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q[k] <= '0;
      else        cfg_q[k] <= cfg_d[k];
    end
  end
endmodule

// File: rtl/ep_layout.sv
module ep_layout
  import ep_alloc_pkg::*;
#(
  parameter int NUM_EP    = 8,
  parameter int RAM_BYTES = 176,
  parameter int SUM_W     = 14
) (
  input  ep_cfg_t          cfg   [NUM_EP],
  output logic [SUM_W-1:0] base  [NUM_EP],
  output logic [SUM_W-1:0] bytes [NUM_EP],
  output logic [NUM_EP-1:0] ovf,
  output logic [NUM_EP-1:0] valid
);
  always_comb begin
    logic [SUM_W-1:0] run;
    logic [SUM_W-1:0] stop;
    logic             hit;
    run = '0;
    hit = 1'b0;
    for (int k = 0; k < NUM_EP; k++) begin
      base[k]  = run;
      bytes[k] = cfg[k].alloc ? SUM_W'(region_bytes(cfg[k].code, cfg[k].bank)) : '0;
      stop     = run + bytes[k];
      ovf[k]   = cfg[k].alloc && (stop > SUM_W'(RAM_BYTES));
      hit      = hit | ovf[k];
      valid[k] = cfg[k].alloc && !hit;
      run      = stop;
    end
  end
endmodule

// File: rtl/ep_reloc_track.sv
module ep_reloc_track #(
  parameter int NUM_EP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] set,
  input  logic [NUM_EP-1:0] clr,
  output logic [NUM_EP-1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/ep_access_map.sv
module ep_access_map #(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 3,
  parameter int SUM_W  = 14,
  parameter int OFF_W  = 10,
  parameter int ADDR_W = 8
) (
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [EP_W-1:0]   acc_ep,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic              acc_write,
  input  logic [SUM_W-1:0]  base  [NUM_EP],
  input  logic [SUM_W-1:0]  bytes [NUM_EP],
  input  logic [NUM_EP-1:0] valid,
  output logic              ram_req_valid,
  input  logic              ram_req_ready,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              acc_err
);
  logic [SUM_W-1:0] phys;
  logic             bad;

  assign bad           = !valid[acc_ep] || (SUM_W'(acc_off) >= bytes[acc_ep]);
  assign phys          = base[acc_ep] + SUM_W'(acc_off);
  assign ram_addr      = ADDR_W'(phys);
  assign acc_err       = acc_valid && bad;
  assign ram_req_valid = acc_valid && !bad;
  assign ram_we        = ram_req_valid && acc_write;
  assign acc_ready     = bad ? 1'b1 : ram_req_ready;
endmodule

// File: rtl/ep_buf_alloc.sv
module ep_buf_alloc
  import ep_alloc_pkg::*;
#(
  parameter int NUM_EP    = 8,
  parameter int RAM_BYTES = 176,
  parameter int EP_W      = $clog2(NUM_EP),
  parameter int SUM_W     = $clog2(NUM_EP * 1024 + 1),
  parameter int OFF_W     = 10,
  parameter int ADDR_W    = $clog2(RAM_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [EP_W-1:0]         cfg_ep,
  input  logic                    cfg_en,
  input  logic                    cfg_alloc,
  input  logic [2:0]              cfg_size,
  input  logic                    cfg_bank,
  input  logic [NUM_EP-1:0]       rel_clr,
  output logic [NUM_EP-1:0]       ep_enabled,
  output logic [NUM_EP*SUM_W-1:0] ep_base,
  output logic [NUM_EP*SUM_W-1:0] ep_bytes,
  output logic [NUM_EP-1:0]       ep_valid,
  output logic [NUM_EP-1:0]       ep_ovf,
  output logic [NUM_EP-1:0]       ep_reloc,
  input  logic                    acc_valid,
  output logic                    acc_ready,
  input  logic [EP_W-1:0]         acc_ep,
  input  logic [OFF_W-1:0]        acc_off,
  input  logic                    acc_write,
  output logic                    ram_req_valid,
  input  logic                    ram_req_ready,
  output logic                    ram_we,
  output logic [ADDR_W-1:0]       ram_addr,
  output logic                    acc_err
);
  ep_cfg_t          cfg_word;
  ep_cfg_t          cfg_q [NUM_EP];
  ep_cfg_t          cfg_d [NUM_EP];
  logic [SUM_W-1:0] base_d  [NUM_EP];
  logic [SUM_W-1:0] bytes_d [NUM_EP];
  logic [SUM_W-1:0] base_q  [NUM_EP];
  logic [SUM_W-1:0] bytes_q [NUM_EP];
  logic [NUM_EP-1:0] ovf_d, valid_d, moved;

  assign cfg_word = '{en: cfg_en, alloc: cfg_alloc, code: cfg_size, bank: cfg_bank};

  ep_cfg_regs #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ep(cfg_ep),
    .cfg_word(cfg_word), .cfg_q(cfg_q), .cfg_d(cfg_d)
  );

  // Layout is computed from the next configuration so it lands on the same edge.
  ep_layout #(.NUM_EP(NUM_EP), .RAM_BYTES(RAM_BYTES), .SUM_W(SUM_W)) u_layout (
    .cfg(cfg_d), .base(base_d), .bytes(bytes_d), .ovf(ovf_d), .valid(valid_d)
  );

  for (genvar k = 0; k < NUM_EP; k++) begin : g_out
    assign moved[k] = cfg_q[k].alloc && cfg_d[k].alloc && (base_d[k] != base_q[k]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[k]  <= '0;
        bytes_q[k] <= '0;
      end else begin
        base_q[k]  <= base_d[k];
        bytes_q[k] <= bytes_d[k];
      end
    end

    assign ep_base [k*SUM_W +: SUM_W] = base_q[k];
    assign ep_bytes[k*SUM_W +: SUM_W] = bytes_q[k];
    assign ep_enabled[k]              = cfg_q[k].en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_valid <= '0;
      ep_ovf   <= '0;
    end else begin
      ep_valid <= valid_d;
      ep_ovf   <= ovf_d;
    end
  end

  ep_reloc_track #(.NUM_EP(NUM_EP)) u_reloc (
    .clk(clk), .rst_n(rst_n), .set(moved), .clr(rel_clr), .flags(ep_reloc)
  );

  ep_access_map #(
    .NUM_EP(NUM_EP), .EP_W(EP_W), .SUM_W(SUM_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) u_map (
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_ep(acc_ep), .acc_off(acc_off),
    .acc_write(acc_write), .base(base_q), .bytes(bytes_q), .valid(ep_valid),
    .ram_req_valid(ram_req_valid), .ram_req_ready(ram_req_ready), .ram_we(ram_we),
    .ram_addr(ram_addr), .acc_err(acc_err)
  );
endmodule

// File: rtl/ep_buf_alloc_chk.sv
module ep_buf_alloc_chk #(
  parameter int NUM_EP = 8,
  parameter int SUM_W  = 14
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [NUM_EP-1:0]       rel_clr,
  input logic [NUM_EP*SUM_W-1:0] ep_base,
  input logic [NUM_EP-1:0]       ep_valid,
  input logic [NUM_EP-1:0]       ep_ovf,
  input logic [NUM_EP-1:0]       ep_reloc,
  input logic                    acc_valid,
  input logic                    acc_ready,
  input logic                    acc_write,
  input logic                    acc_err,
  input logic                    ram_req_valid,
  input logic                    ram_req_ready,
  input logic                    ram_we
);
  logic [NUM_EP-1:0] above_ovf;

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < NUM_EP; k++) begin
      seen         = seen | ep_ovf[k];
      above_ovf[k] = seen;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_valid & above_ovf) == '0);

  assert_layout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(ep_base));

  assert_reloc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ep_reloc) & ~$past(rel_clr)) & ~ep_reloc) == '0));

  assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (!ram_we && !ram_req_valid && acc_ready));

  assert_we_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_req_valid && acc_write && acc_valid));

  assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req_valid && !ram_req_ready) |-> !acc_ready);
endmodule

bind ep_buf_alloc ep_buf_alloc_chk #(.NUM_EP(NUM_EP), .SUM_W(SUM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .rel_clr(rel_clr), .ep_base(ep_base),
  .ep_valid(ep_valid), .ep_ovf(ep_ovf), .ep_reloc(ep_reloc), .acc_valid(acc_valid),
  .acc_ready(acc_ready), .acc_write(acc_write), .acc_err(acc_err),
  .ram_req_valid(ram_req_valid), .ram_req_ready(ram_req_ready), .ram_we(ram_we)
);

// File: tb/ep_buf_alloc_tb_top.sv
`timescale 1ns/1ps
module ep_buf_alloc_tb_top;
  localparam int NUM_EP = 8;
  localparam int SUM_W  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_ep = '0;
  logic cfg_en = 1'b0, cfg_alloc = 1'b0, cfg_bank = 1'b0;
  logic [2:0] cfg_size = '0;
  logic [NUM_EP-1:0] rel_clr = '0;
  logic [NUM_EP-1:0] ep_enabled, ep_valid, ep_ovf, ep_reloc;
  logic [NUM_EP*SUM_W-1:0] ep_base, ep_bytes;
  logic acc_valid = 1'b0, acc_write = 1'b0, ram_req_ready = 1'b1;
  logic [2:0] acc_ep = '0;
  logic [9:0] acc_off = '0;
  logic acc_ready, ram_req_valid, ram_we, acc_err;
  logic [7:0] ram_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ep_buf_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_en(cfg_en),
    .cfg_alloc(cfg_alloc), .cfg_size(cfg_size), .cfg_bank(cfg_bank), .rel_clr(rel_clr),
    .ep_enabled(ep_enabled), .ep_base(ep_base), .ep_bytes(ep_bytes), .ep_valid(ep_valid),
    .ep_ovf(ep_ovf), .ep_reloc(ep_reloc), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_ep(acc_ep), .acc_off(acc_off), .acc_write(acc_write),
    .ram_req_valid(ram_req_valid), .ram_req_ready(ram_req_ready), .ram_we(ram_we),
    .ram_addr(ram_addr), .acc_err(acc_err)
  );

  function automatic int base_of(int k);
    return int'(ep_base[k*SUM_W +: SUM_W]);
  endfunction

  function automatic int len_of(int k);
    return int'(ep_bytes[k*SUM_W +: SUM_W]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One configuration write; returns at the falling edge after the accepting edge.
  task automatic cfg_write(int ep, bit en, bit al, int code, bit bank);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ep = 3'(ep); cfg_en = en; cfg_alloc = al;
    cfg_size = 3'(code); cfg_bank = bank;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_reloc(logic [NUM_EP-1:0] m);
    @(negedge clk);
    rel_clr = m;
    @(negedge clk);
    rel_clr = '0;
  endtask

  task automatic t_reset;
    chk("R1", "base1", base_of(1), 0);
    chk("R1", "bytes0", len_of(0), 0);
    chk("R1", "valid", int'(ep_valid), 0);
    chk("R1", "ovf", int'(ep_ovf), 0);
    chk("R1", "reloc", int'(ep_reloc), 0);
    chk("R1", "enabled", int'(ep_enabled), 0);
  endtask

  task automatic t_pack;
    cfg_write(0, 1, 1, 0, 0);
    chk("R2", "bytes0 same edge", len_of(0), 8);
    cfg_write(1, 1, 1, 1, 0);
    cfg_write(2, 1, 1, 2, 0);
    chk("R2", "base1", base_of(1), 8);
    chk("R2", "base2", base_of(2), 24);
    chk("R2", "bytes2", len_of(2), 32);
    chk("R2", "valid", int'(ep_valid), 'b111);
    chk("R2", "base3 unallocated", base_of(3), 56);
    chk("R2", "bytes3 unallocated", len_of(3), 0);
  endtask

  task automatic t_free;
    cfg_write(1, 1, 0, 1, 0);
    chk("R4", "base2 slides down", base_of(2), 8);
    chk("R4", "base0 kept", base_of(0), 0);
    chk("R4", "bytes1 freed", len_of(1), 0);
    chk("R7", "reloc after free", int'(ep_reloc), 'b100);
    repeat (3) @(negedge clk);
    chk("R7", "reloc sticky", int'(ep_reloc), 'b100);
    clear_reloc('b100);
    chk("R7", "reloc cleared", int'(ep_reloc), 0);
  endtask

  task automatic t_realloc;
    cfg_write(1, 1, 1, 2, 0);
    chk("R5", "base2 slides up", base_of(2), 40);
    chk("R5", "base1", base_of(1), 8);
    chk("R5", "base0 kept", base_of(0), 0);
    chk("R7", "reloc after alloc", int'(ep_reloc), 'b100);
    clear_reloc('b100);
  endtask

  task automatic t_enable;
    cfg_write(1, 0, 1, 2, 0);
    chk("R6", "enabled bit", int'(ep_enabled[1]), 0);
    chk("R6", "base2 kept", base_of(2), 40);
    chk("R6", "bytes1 kept", len_of(1), 32);
    chk("R6", "valid kept", int'(ep_valid), 'b111);
    chk("R6", "no reloc", int'(ep_reloc), 0);
    cfg_write(1, 1, 1, 2, 0);
  endtask

  task automatic t_overflow;
    cfg_write(3, 1, 1, 4, 0);
    chk("R3", "base3", base_of(3), 72);
    chk("R3", "ovf3", int'(ep_ovf), 'b1000);
    chk("R3", "valid low kept", int'(ep_valid), 'b0111);
    cfg_write(4, 1, 1, 0, 0);
    chk("R3", "ovf4", int'(ep_ovf), 'b11000);
    chk("R3", "valid4 low", int'(ep_valid), 'b00111);
    cfg_write(3, 1, 0, 4, 0);
    chk("R4", "base4 back down", base_of(4), 72);
    chk("R3", "ovf cleared", int'(ep_ovf), 0);
    chk("R3", "valid4 back", int'(ep_valid), 'b10111);
    chk("R7", "reloc4", int'(ep_reloc), 'b10000);
    clear_reloc('b10000);
    cfg_write(5, 1, 1, 7, 1);
    chk("R2", "code7 bank len", len_of(5), 1024);
    chk("R3", "ovf5", int'(ep_ovf), 'b100000);
    cfg_write(5, 1, 0, 7, 1);
    chk("R2", "freed5 len", len_of(5), 0);
  endtask

  task automatic t_access;
    @(negedge clk);
    acc_valid = 1'b1; acc_ep = 3'd2; acc_off = 10'd5; acc_write = 1'b1; ram_req_ready = 1'b1;
    #1;
    chk("R8", "addr", int'(ram_addr), 45);
    chk("R8", "we", int'(ram_we), 1);
    chk("R8", "req_valid", int'(ram_req_valid), 1);
    chk("R8", "no err", int'(acc_err), 0);
    acc_write = 1'b0; acc_off = 10'd31;
    #1;
    chk("R8", "read no we", int'(ram_we), 0);
    chk("R8", "last byte addr", int'(ram_addr), 71);
    ram_req_ready = 1'b0;
    #1;
    chk("R10", "held by ram", int'(acc_ready), 0);
    chk("R10", "req stays", int'(ram_req_valid), 1);
    ram_req_ready = 1'b1;
    #1;
    chk("R10", "accepted", int'(acc_ready), 1);
    acc_off = 10'd32; acc_write = 1'b1; ram_req_ready = 1'b0;
    #1;
    chk("R9", "offset err", int'(acc_err), 1);
    chk("R9", "no we", int'(ram_we), 0);
    chk("R9", "no req", int'(ram_req_valid), 0);
    chk("R9", "consumed", int'(acc_ready), 1);
    acc_ep = 3'd6; acc_off = 10'd0;
    #1;
    chk("R9", "invalid ep err", int'(acc_err), 1);
    chk("R9", "invalid ep no we", int'(ram_we), 0);
    acc_valid = 1'b0; ram_req_ready = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pack();
    t_free();
    t_realloc();
    t_enable();
    t_overflow();
    t_access();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule